// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Address Generator

This block decides whether a processor core should take a hardware interrupt, and where the handler lives. Each interrupt line reports its level through an indexed write port. The level lands in that line's bit of a pending-status register. A programmable enable mask filters the pending bits. Any surviving bit raises an interrupt request. The request becomes a take event only while interrupts are globally enabled and the core is not in debug state.

On a take event the block pulses a one-cycle strobe. It also presents the number of the highest-numbered pending and enabled line, and the handler address for that line. The address is the entry base plus the sum of a fixed code offset and the line number, scaled by a power-of-two vector spacing. A spacing code of zero makes every vector land on the base address. The block never clears pending bits. The interrupt source owns them, so a line stays pending until its source writes a zero.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A write with `line_wr_valid`=1 and `line_wr_idx` below NUM_LINES stores `line_wr_level` in the pending bit of that line. The next cycle's `irq_req` reflects it.
- R2: A write whose `line_wr_idx` is NUM_LINES or above changes no pending bit and raises no request.
- R3: `irq_req` is 1 exactly when some line is both pending and enabled in the mask.
- R4: A take event occurs only while `glb_ie` is 1 and `dbg_active` is 0. With either condition failing, `take_o` stays 0 however long the request is held.
- R5: `take_o` is a single-cycle pulse. It is raised in the cycle after the eligibility condition (request AND `glb_ie` AND NOT `dbg_active`) becomes true. It does not repeat while that condition stays true.
- R6: With `take_o`, `vec_o` gives the index of the highest-numbered line that is both pending and enabled.
- R7: With a spacing code S from 1 to 7, `pc_o` = `entry_base` + (CODE_OFFSET + `vec_o`) * 2^(S+2). CODE_OFFSET defaults to 64.
- R8: With spacing code 0, `pc_o` equals `entry_base` for every vector.
- R9: Reset clears the pending bits, the enable mask and the spacing code, and drives `take_o`, `vec_o` and `pc_o` to 0. Until software writes the mask, a pending line raises no request.
- R10: Taking an interrupt does not clear its pending bit, so `irq_req` stays 1 after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_wr_valid | input | 1 | Line level update strobe |
| line_wr_idx | input | LINE_IDX_W | Line being updated |
| line_wr_level | input | 1 | New level of that line |
| cfg_wr | input | 1 | Loads the enable mask and spacing code |
| cfg_mask | input | NUM_LINES | Per-line enable mask |
| cfg_spacing | input | VS_W | Vector spacing code |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_active | input | 1 | Core is in debug state |
| entry_base | input | ADDR_W | Handler entry base address |
| irq_req | output | 1 | Some line is pending and enabled |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | LINE_IDX_W | Selected vector index |
| pc_o | output | ADDR_W | Handler target address |

## Verification
A line write or configuration write is captured at one clock edge, and `irq_req` is correct immediately after that edge. `take_o`, `vec_o` and `pc_o` are registered once more, so they are due after the second edge. A change of `glb_ie` or `dbg_active` acts at the first edge. The bench drives every input on the falling edge and samples on the next falling edge after the number of rising edges each result needs. It then checks the strobe's absence one edge later. The sweep covers every line under every spacing code, with expected addresses computed arithmetically.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int unsigned DEF_LINES       = 13;
   localparam int unsigned DEF_IDX_W       = 4;
   localparam int unsigned DEF_VS_W        = 3;
   localparam int unsigned DEF_ADDR_W      = 64;
   localparam int unsigned DEF_CODE_OFFSET = 64;
   // spacing is 4 bytes times 2^code, i.e. a left shift of code + 2
   localparam int unsigned SPACING_BASE_SHIFT = 2;

   function automatic int unsigned spacing_shift(input int unsigned code);
      return code + SPACING_BASE_SHIFT;
   endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
   parameter int unsigned NUM_LINES  = irq_arb_pkg::DEF_LINES,
   parameter int unsigned LINE_IDX_W = irq_arb_pkg::DEF_IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [LINE_IDX_W-1:0] wr_idx,
   input  logic                  wr_level,
   output logic [NUM_LINES-1:0]  pend
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic hit;
      assign hit = wr_valid && (wr_idx == LINE_IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend[g] <= 1'b0;
         else if (hit)
            pend[g] <= wr_level;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned NUM_LINES  = irq_arb_pkg::DEF_LINES,
   parameter int unsigned LINE_IDX_W = irq_arb_pkg::DEF_IDX_W
) (
   input  logic [NUM_LINES-1:0]  req,
   output logic                  any,
   output logic [LINE_IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (req[i])
            idx = LINE_IDX_W'(i);   // later (higher) index overrides
      end
      any = |req;
   end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int unsigned LINE_IDX_W  = irq_arb_pkg::DEF_IDX_W,
   parameter int unsigned VS_W        = irq_arb_pkg::DEF_VS_W,
   parameter int unsigned ADDR_W      = irq_arb_pkg::DEF_ADDR_W,
   parameter int unsigned CODE_OFFSET = irq_arb_pkg::DEF_CODE_OFFSET
) (
   input  logic [ADDR_W-1:0]     base,
   input  logic [VS_W-1:0]       spacing,
   input  logic [LINE_IDX_W-1:0] vec,
   output logic [ADDR_W-1:0]     target
);
   logic [ADDR_W-1:0] slot;
   logic [ADDR_W-1:0] scaled;

   assign slot   = ADDR_W'(CODE_OFFSET) + ADDR_W'(vec);
   assign scaled = slot << irq_arb_pkg::spacing_shift(int'(spacing));
   assign target = (spacing == '0) ? base : (base + scaled);
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
   parameter int unsigned NUM_LINES   = irq_arb_pkg::DEF_LINES,
   parameter int unsigned LINE_IDX_W  = irq_arb_pkg::DEF_IDX_W,
   parameter int unsigned VS_W        = irq_arb_pkg::DEF_VS_W,
   parameter int unsigned ADDR_W      = irq_arb_pkg::DEF_ADDR_W,
   parameter int unsigned CODE_OFFSET = irq_arb_pkg::DEF_CODE_OFFSET
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_wr_valid,
   input  logic [LINE_IDX_W-1:0] line_wr_idx,
   input  logic                  line_wr_level,
   input  logic                  cfg_wr,
   input  logic [NUM_LINES-1:0]  cfg_mask,
   input  logic [VS_W-1:0]       cfg_spacing,
   input  logic                  glb_ie,
   input  logic                  dbg_active,
   input  logic [ADDR_W-1:0]     entry_base,
   output logic                  irq_req,
   output logic                  take_o,
   output logic [LINE_IDX_W-1:0] vec_o,
   output logic [ADDR_W-1:0]     pc_o
);
   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..32");
   end
   if ((1 << LINE_IDX_W) < NUM_LINES) begin : g_bad_idx
      $error("LINE_IDX_W too narrow for NUM_LINES");
   end
   if (VS_W < 1 || VS_W > 5) begin : g_bad_vs
      $error("VS_W must lie in 1..5");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must be at least 16");
   end

   logic [NUM_LINES-1:0]  pend_q;
   logic [NUM_LINES-1:0]  mask_q;
   logic [VS_W-1:0]       vs_q;
   logic [NUM_LINES-1:0]  masked;
   logic                  any_masked;
   logic [LINE_IDX_W-1:0] sel_idx;
   logic [ADDR_W-1:0]     pc_next;
   logic                  elig;
   logic                  elig_d;
   logic                  take_q;
   logic [LINE_IDX_W-1:0] vec_q;
   logic [ADDR_W-1:0]     pc_q;

   irq_pending_bank #(.NUM_LINES(NUM_LINES), .LINE_IDX_W(LINE_IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (line_wr_valid),
      .wr_idx   (line_wr_idx),
      .wr_level (line_wr_level),
      .pend     (pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         vs_q   <= '0;
      end else if (cfg_wr) begin
         mask_q <= cfg_mask;
         vs_q   <= cfg_spacing;
      end
   end

   assign masked = pend_q & mask_q;

   irq_prio_enc #(.NUM_LINES(NUM_LINES), .LINE_IDX_W(LINE_IDX_W)) u_prio (
      .req (masked),
      .any (any_masked),
      .idx (sel_idx)
   );

   irq_vec_addr #(
      .LINE_IDX_W  (LINE_IDX_W),
      .VS_W        (VS_W),
      .ADDR_W      (ADDR_W),
      .CODE_OFFSET (CODE_OFFSET)
   ) u_addr (
      .base    (entry_base),
      .spacing (vs_q),
      .vec     (sel_idx),
      .target  (pc_next)
   );

   assign irq_req = any_masked;
   assign elig    = any_masked && glb_ie && !dbg_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elig_d <= 1'b0;
         take_q <= 1'b0;
         vec_q  <= '0;
         pc_q   <= '0;
      end else begin
         elig_d <= elig;
         take_q <= elig && !elig_d;
         vec_q  <= sel_idx;
         pc_q   <= pc_next;
      end
   end

   assign take_o = take_q;
   assign vec_o  = vec_q;
   assign pc_o   = pc_q;
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
   parameter int unsigned NUM_LINES  = irq_arb_pkg::DEF_LINES,
   parameter int unsigned LINE_IDX_W = irq_arb_pkg::DEF_IDX_W,
   parameter int unsigned VS_W       = irq_arb_pkg::DEF_VS_W,
   parameter int unsigned ADDR_W     = irq_arb_pkg::DEF_ADDR_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  line_wr_valid,
   input logic [LINE_IDX_W-1:0] line_wr_idx,
   input logic                  glb_ie,
   input logic                  dbg_active,
   input logic [ADDR_W-1:0]     entry_base,
   input logic [NUM_LINES-1:0]  pend_q,
   input logic [VS_W-1:0]       vs_q,
   input logic                  irq_req,
   input logic                  take_o,
   input logic [LINE_IDX_W-1:0] vec_o,
   input logic [ADDR_W-1:0]     pc_o
);
   logic started_q;
   always_ff @(posedge clk) begin
      if (!rst_n) started_q <= 1'b0;
      else        started_q <= 1'b1;
   end

   assert_oob_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_wr_valid && (int'(line_wr_idx) >= NUM_LINES)) |=> (pend_q == $past(pend_q)));

   assert_take_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && take_o) |-> $past(irq_req));

   assert_take_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && take_o) |-> ($past(glb_ie) && !$past(dbg_active)));

   assert_take_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o);

   assert_vec_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (int'(vec_o) < NUM_LINES));

   assert_zero_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && ($past(vs_q) == '0)) |-> (pc_o == $past(entry_base)));
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
   .NUM_LINES  (NUM_LINES),
   .LINE_IDX_W (LINE_IDX_W),
   .VS_W       (VS_W),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .line_wr_valid (line_wr_valid),
   .line_wr_idx   (line_wr_idx),
   .glb_ie        (glb_ie),
   .dbg_active    (dbg_active),
   .entry_base    (entry_base),
   .pend_q        (pend_q),
   .vs_q          (vs_q),
   .irq_req       (irq_req),
   .take_o        (take_o),
   .vec_o         (vec_o),
   .pc_o          (pc_o)
);

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;
   localparam int NL   = 13;
   localparam int IW   = 4;
   localparam int VW   = 3;
   localparam int AW   = 64;
   localparam int COFF = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_wr_valid = 1'b0;
   logic [IW-1:0] line_wr_idx = '0;
   logic          line_wr_level = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [NL-1:0] cfg_mask = '0;
   logic [VW-1:0] cfg_spacing = '0;
   logic          glb_ie = 1'b0;
   logic          dbg_active = 1'b0;
   logic [AW-1:0] entry_base = '0;
   logic          irq_req;
   logic          take_o;
   logic [IW-1:0] vec_o;
   logic [AW-1:0] pc_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_vector_arbiter uut (
      .clk(clk), .rst_n(rst_n),
      .line_wr_valid(line_wr_valid), .line_wr_idx(line_wr_idx), .line_wr_level(line_wr_level),
      .cfg_wr(cfg_wr), .cfg_mask(cfg_mask), .cfg_spacing(cfg_spacing),
      .glb_ie(glb_ie), .dbg_active(dbg_active), .entry_base(entry_base),
      .irq_req(irq_req), .take_o(take_o), .vec_o(vec_o), .pc_o(pc_o)
   );

   task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, release at next falling edge
   task automatic wr_line(input int idx, input bit lvl);
      @(negedge clk);
      line_wr_valid = 1'b1;
      line_wr_idx   = IW'(idx);
      line_wr_level = lvl;
      @(negedge clk);
      line_wr_valid = 1'b0;
   endtask

   task automatic wr_cfg(input logic [NL-1:0] m, input int vs);
      @(negedge clk);
      cfg_wr      = 1'b1;
      cfg_mask    = m;
      cfg_spacing = VW'(vs);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [AW-1:0] exp_pc(input logic [AW-1:0] b, input int vs, input int v);
      logic [AW-1:0] sp;
      if (vs == 0) return b;
      sp = AW'(4) << vs;
      return b + AW'(COFF + v) * sp;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(irq_req == 1'b0, "R9 reset irq_req", AW'(irq_req), 0);
      check(take_o == 1'b0,  "R9 reset take_o", AW'(take_o), 0);
      check(vec_o == '0,     "R9 reset vec_o", AW'(vec_o), 0);
      check(pc_o == '0,      "R9 reset pc_o", pc_o, 0);
      // R9: mask cleared by reset, pending line raises nothing
      glb_ie = 1'b1;
      wr_line(5, 1'b1);
      check(irq_req == 1'b0, "R9 mask zero after reset", AW'(irq_req), 0);
      idle(1);
      check(take_o == 1'b0, "R9 no take with zero mask", AW'(take_o), 0);
      wr_line(5, 1'b0);
      idle(2);

      // R2: out-of-range indices ignored
      wr_cfg({NL{1'b1}}, 1);
      for (int k = NL; k < (1 << IW); k++) begin
         wr_line(k, 1'b1);
         check(irq_req == 1'b0, "R2 out-of-range write ignored", AW'(irq_req), 0);
         @(negedge clk);
         check(take_o == 1'b0, "R2 no take after out-of-range write", AW'(take_o), 0);
      end

      // sweep every spacing code and every line
      for (int vs = 0; vs < 8; vs++) begin
         entry_base = 64'h9000_0000_1c00_0000 + AW'(vs) * 64'h1_0000;
         wr_cfg({NL{1'b1}}, vs);
         idle(1);
         for (int l = 0; l < NL; l++) begin
            wr_line(l, 1'b1);   // edge1 captured; now past edge1
            check(irq_req == 1'b1, "R1 line write sets request", AW'(irq_req), 1);
            check(take_o == 1'b0, "R5 strobe not yet due", AW'(take_o), 0);
            @(negedge clk);     // past edge2
            check(take_o == 1'b1, "R5 take strobe", AW'(take_o), 1);
            check(vec_o == IW'(l), "R6 vector index", AW'(vec_o), AW'(l));
            if (vs == 0)
               check(pc_o == entry_base, "R8 zero spacing address", pc_o, entry_base);
            else
               check(pc_o == exp_pc(entry_base, vs, l), "R7 vector address", pc_o,
                     exp_pc(entry_base, vs, l));
            @(negedge clk);
            check(take_o == 1'b0, "R5 strobe single cycle", AW'(take_o), 0);
            check(irq_req == 1'b1, "R10 pending kept after take", AW'(irq_req), 1);
            wr_line(l, 1'b0);
            check(irq_req == 1'b0, "R1 line write clears request", AW'(irq_req), 0);
            idle(1);
         end
      end

      // R3 and R6: mask filters, highest masked line wins
      glb_ie = 1'b0;
      entry_base = 64'h0000_0000_1c00_0000;
      wr_cfg(NL'(13'h0FFF), 1);   // line 12 disabled
      wr_line(3, 1'b1);
      wr_line(9, 1'b1);
      wr_line(12, 1'b1);
      check(irq_req == 1'b1, "R3 request from masked lines", AW'(irq_req), 1);
      idle(3);
      check(take_o == 1'b0, "R4 no take with global enable off", AW'(take_o), 0);
      @(negedge clk);
      glb_ie = 1'b1;
      @(negedge clk);
      check(take_o == 1'b1, "R4 take once enabled", AW'(take_o), 1);
      check(vec_o == IW'(9), "R6 masked line skipped", AW'(vec_o), 9);
      check(pc_o == exp_pc(entry_base, 1, 9), "R7 address for line 9", pc_o,
            exp_pc(entry_base, 1, 9));
      glb_ie = 1'b0;
      wr_cfg({NL{1'b1}}, 2);
      glb_ie = 1'b1;
      @(negedge clk);
      check(take_o == 1'b1, "R6 take with full mask", AW'(take_o), 1);
      check(vec_o == IW'(12), "R6 highest line wins", AW'(vec_o), 12);
      check(pc_o == exp_pc(entry_base, 2, 12), "R7 address for line 12", pc_o,
            exp_pc(entry_base, 2, 12));
      idle(3);
      check(take_o == 1'b0, "R5 no repeat while held", AW'(take_o), 0);

      // R4: debug state blocks the take
      glb_ie = 1'b0;
      @(negedge clk);
      dbg_active = 1'b1;
      glb_ie = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(take_o == 1'b0, "R4 debug blocks take", AW'(take_o), 0);
      end
      dbg_active = 1'b0;
      @(negedge clk);
      check(take_o == 1'b1, "R4 take after debug exit", AW'(take_o), 1);
      check(vec_o == IW'(12), "R6 vector after debug exit", AW'(vec_o), 12);

      // R3: clearing the mask drops the request
      wr_cfg('0, 2);
      check(irq_req == 1'b0, "R3 request drops with mask cleared", AW'(irq_req), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule